// File: doc/BRIEF.md
# Compressed Stream Output Port

This block hands a demultiplexed compressed byte stream, made of interleaved video and audio bytes, to a downstream decoder. Bytes arrive through a valid/ready handshake. Each byte carries a tag that says whether it is audio, and a flag that says whether it is corrupt. The port holds one byte at a time. It sends that byte only while the decoder requests data of the matching type.

Two delivery modes share one data path:

- **Serial mode.** The byte is shifted out most significant bit first on a single data line. A bit clock runs alongside it at half the core clock rate.
- **Parallel mode.** The byte is placed on an 8-bit bus one clock before the type's strobe rises. The rising edge of that strobe is the receiver's capture edge.

In both modes a separate strobe marks video and audio. An active-low error line marks corrupt bytes, and it is low only inside the strobe window of such a byte.

Top module: `stream_out_port`

## Requirements
- R1: While reset is asserted, and after it is released with no traffic, both strobes are low, the error line is high, the bit clock and serial line are low, the parallel bus is 0 and `in_ready` is high.
- R2: In serial mode a byte is sent as exactly 8 rising edges of `ser_clk`, with the most significant bit first. `ser_data` is unchanged across each rising edge, and the byte's strobe stays high for all 8 bits.
- R3: `vid_vld` is high only while a byte tagged video (`in_is_audio`=0) is presented. `aud_vld` is high only for a byte tagged audio (`in_is_audio`=1). The two strobes are never high together.
- R4: A video byte starts only while `vreq_n` is low, and an audio byte starts only while `areq_n` is low. A held byte waits as long as its request is high.
- R5: `err_n` is low exactly during the strobe window of a byte accepted with `in_err`=1, and is high at all other times.
- R6: In parallel mode the byte is on `par_data` one clock before the strobe rises. The strobe stays high for one clock and then is low for at least one clock. `par_data` is unchanged from the clock before the rise through the rise itself.
- R7: If the request is withdrawn while a byte is in progress, that byte still completes.
- R8: The port holds at most one byte. After a handshake completes, `in_ready` is low until that byte has been fully sent.
- R9: `mode_par` (0 = serial, 1 = parallel) is taken when a byte starts. Each byte is sent entirely in the mode selected while the port was idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_par | input | 1 | 1 selects parallel mode, 0 selects serial mode |
| in_valid | input | 1 | Upstream byte valid |
| in_ready | output | 1 | Port can accept a byte |
| in_data | input | 8 | Upstream byte |
| in_is_audio | input | 1 | Byte is audio (1) or video (0) |
| in_err | input | 1 | Byte is corrupt |
| vreq_n | input | 1 | Active-low video request from the decoder |
| areq_n | input | 1 | Active-low audio request from the decoder |
| ser_data | output | 1 | Serial data line |
| ser_clk | output | 1 | Serial bit clock; the receiver samples on its rising edge |
| vid_vld | output | 1 | Video strobe |
| aud_vld | output | 1 | Audio strobe |
| err_n | output | 1 | Active-low error marker, qualified by the strobes |
| par_data | output | 8 | Parallel data bus |

## Verification
Two events can fall in the same cycle: a request is withdrawn, and a byte transfer is already in progress. The bench provokes this by raising `vreq_n` a few cycles after `vid_vld` rises in serial mode. It then checks that all 8 bits still arrive and that exactly one byte is counted. A second overlap occurs when the error marker and the strobe edges coincide. In both modes, the error value is checked against each byte's flag at every receiver capture edge. The bench also flags any cycle where `err_n` is low while no strobe is high.

// File: rtl/stream_out_pkg.sv
package stream_out_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_SER,
    ST_PSET,
    ST_PSTB,
    ST_PGAP
  } port_st_e;
endpackage

// File: rtl/sop_rst_sync.sv
module sop_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q       <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      s1_q       <= 1'b1;
      rst_sync_n <= s1_q;
    end
  end
endmodule

// File: rtl/sop_shift.sv
module sop_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  input  logic         shift_en,
  output logic [W-1:0] hold_q,
  output logic         msb
);
  logic [W-1:0] sh_q, sh_d, hold_d;

  always_comb begin
    hold_d = hold_q;
    sh_d   = sh_q;
    if (load) begin
      hold_d = d;
      sh_d   = d;
    end else if (shift_en) begin
      sh_d = {sh_q[W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      sh_q   <= '0;
    end else begin
      hold_q <= hold_d;
      sh_q   <= sh_d;
    end
  end

  assign msb = sh_q[W-1];
endmodule

// File: rtl/sop_fsm.sv
module sop_fsm
  import stream_out_pkg::*;
#(
  parameter int               CNT_W    = 4,
  parameter logic [CNT_W-1:0] CNT_LAST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_is_audio,
  input  logic             in_err,
  input  logic             mode_par,
  input  logic             vreq_n,
  input  logic             areq_n,
  output port_st_e         st,
  output logic [CNT_W-1:0] cnt,
  output logic             load,
  output logic             shift_en,
  output logic             aud_q,
  output logic             err_q,
  output logic             par_q
);
  port_st_e         st_d;
  logic [CNT_W-1:0] cnt_d;
  logic             start, req_ok;

  assign req_ok = aud_q ? !areq_n : !vreq_n;

  always_comb begin
    st_d     = st;
    cnt_d    = cnt;
    load     = 1'b0;
    shift_en = 1'b0;
    start    = 1'b0;
    case (st)
      ST_IDLE: if (in_valid) begin
        load = 1'b1;
        st_d = ST_WAIT;
      end
      ST_WAIT: if (req_ok) begin
        start = 1'b1;
        cnt_d = '0;
        st_d  = mode_par ? ST_PSET : ST_SER;
      end
      ST_SER: begin
        shift_en = cnt[0];
        cnt_d    = cnt + 1'b1;
        if (cnt == CNT_LAST) st_d = ST_IDLE;
      end
      ST_PSET: st_d = ST_PSTB;
      ST_PSTB: st_d = ST_PGAP;
      ST_PGAP: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      aud_q <= 1'b0;
      err_q <= 1'b0;
      par_q <= 1'b0;
    end else begin
      st  <= st_d;
      cnt <= cnt_d;
      if (load) begin
        aud_q <= in_is_audio;
        err_q <= in_err;
      end
      if (start) par_q <= mode_par;
    end
  end
endmodule

// File: rtl/stream_out_port.sv
module stream_out_port
  import stream_out_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_par,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_is_audio,
  input  logic              in_err,
  input  logic              vreq_n,
  input  logic              areq_n,
  output logic              ser_data,
  output logic              ser_clk,
  output logic              vid_vld,
  output logic              aud_vld,
  output logic              err_n,
  output logic [BYTE_W-1:0] par_data
);
  localparam int               SER_TICKS = 2 * BYTE_W;
  localparam int               CNT_W     = $clog2(SER_TICKS);
  localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(SER_TICKS - 1);

  logic              rst_i_n;
  port_st_e          st;
  logic [CNT_W-1:0]  cnt;
  logic              load, shift_en, aud_q, err_q, par_q, msb;
  logic [BYTE_W-1:0] hold_q;
  logic              win, par_busy;

  sop_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  sop_fsm #(.CNT_W(CNT_W), .CNT_LAST(CNT_LAST)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .in_valid    (in_valid),
    .in_is_audio (in_is_audio),
    .in_err      (in_err),
    .mode_par    (mode_par),
    .vreq_n      (vreq_n),
    .areq_n      (areq_n),
    .st          (st),
    .cnt         (cnt),
    .load        (load),
    .shift_en    (shift_en),
    .aud_q       (aud_q),
    .err_q       (err_q),
    .par_q       (par_q)
  );

  sop_shift #(.W(BYTE_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .load     (load),
    .d        (in_data),
    .shift_en (shift_en),
    .hold_q   (hold_q),
    .msb      (msb)
  );

  // Strobe window: every tick of a serial byte, or the single strobe clock in parallel
  assign win      = (st == ST_SER) || (st == ST_PSTB);
  assign par_busy = (st == ST_PSET) || (st == ST_PSTB) || (st == ST_PGAP);

  assign in_ready = (st == ST_IDLE);
  assign vid_vld  = win && !aud_q;
  assign aud_vld  = win && aud_q;
  assign err_n    = !(win && err_q);
  assign ser_clk  = (st == ST_SER) && cnt[0];
  assign ser_data = (st == ST_SER) && msb;
  assign par_data = par_busy ? hold_q : '0;
endmodule

module sop_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              vreq_n,
  input logic              ser_data,
  input logic              ser_clk,
  input logic              vid_vld,
  input logic              aud_vld,
  input logic              err_n,
  input logic              par_q,
  input logic [BYTE_W-1:0] par_data
);
  // R3
  strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(vid_vld && aud_vld));

  // R5
  err_outside_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(vid_vld || aud_vld) |-> err_n);

  // R2
  ser_bit_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk |-> $stable(ser_data));

  // R6
  par_strobe_one_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((vid_vld || aud_vld) && par_q) |=> !(vid_vld || aud_vld));

  // R6
  par_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(vid_vld || aud_vld) && par_q) |-> $stable(par_data));

  // R4
  video_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(vid_vld) && !par_q) |-> !$past(vreq_n));

  // R8
  one_byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
endmodule

bind stream_out_port sop_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .vreq_n   (vreq_n),
  .ser_data (ser_data),
  .ser_clk  (ser_clk),
  .vid_vld  (vid_vld),
  .aud_vld  (aud_vld),
  .err_n    (err_n),
  .par_q    (par_q),
  .par_data (par_data)
);

// File: tb/sim_stream_out_port.sv
`timescale 1ns/1ps
module sim_stream_out_port;
  logic       clk, rst_n, mode_par, in_valid, in_ready, in_is_audio, in_err;
  logic       vreq_n, areq_n, ser_data, ser_clk, vid_vld, aud_vld, err_n;
  logic [7:0] in_data, par_data;

  int total = 0, bad = 0, rcv = 0;
  bit done = 0, mon_en = 0, tb_par = 0;
  logic [7:0] exp_d[$];
  bit exp_a[$], exp_e[$];

  logic       p_clk, p_vid, p_aud, p_sdat;
  logic [7:0] p_par, acc;
  int         nb;
  bit         b_aud, b_err, gap_chk;

  stream_out_port u0 (
    .clk(clk), .rst_n(rst_n), .mode_par(mode_par), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_is_audio(in_is_audio),
    .in_err(in_err), .vreq_n(vreq_n), .areq_n(areq_n), .ser_data(ser_data),
    .ser_clk(ser_clk), .vid_vld(vid_vld), .aud_vld(aud_vld), .err_n(err_n),
    .par_data(par_data)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic take_byte(input logic [7:0] d, input bit a, input bit e, input string req);
    rcv++;
    if (exp_d.size() == 0) begin
      chk(0, {req, " unexpected byte"}, d, 0);
    end else begin
      logic [7:0] xd;
      bit xa, xe;
      xd = exp_d.pop_front(); xa = exp_a.pop_front(); xe = exp_e.pop_front();
      chk(d == xd, req, d, xd);
      chk(a == xa, "R3 strobe type", a, xa);
      chk(e == xe, "R5 error marker", e, xe);
    end
  endtask

  // receiver model
  always @(negedge clk) begin
    if (mon_en) begin
      if (vid_vld && aud_vld) chk(0, "R3 both strobes", 1, 0);
      if (!(vid_vld || aud_vld) && !err_n) chk(0, "R5 err outside window", 0, 1);
      if (!tb_par) begin
        if (ser_clk && !p_clk) begin
          if (!(vid_vld || aud_vld)) chk(0, "R2 clock edge without strobe", 0, 1);
          if (ser_data != p_sdat) chk(0, "R2 bit unstable", ser_data, p_sdat);
          if (nb == 0) begin
            b_aud = aud_vld; b_err = !err_n;
          end else if (b_err != !err_n) chk(0, "R5 err changed in byte", !err_n, b_err);
          acc = {acc[6:0], ser_data};
          nb++;
          if (nb == 8) begin
            take_byte(acc, b_aud, b_err, "R2 serial byte");
            nb = 0;
          end
        end
      end else begin
        if (gap_chk) begin
          chk(!(vid_vld || aud_vld), "R6 strobe width", vid_vld | aud_vld, 0);
          gap_chk = 0;
        end
        if ((vid_vld && !p_vid) || (aud_vld && !p_aud)) begin
          chk(par_data == p_par, "R6 setup", p_par, par_data);
          take_byte(par_data, aud_vld, !err_n, "R6 parallel byte");
          gap_chk = 1;
        end
      end
    end
    p_clk = ser_clk; p_vid = vid_vld; p_aud = aud_vld; p_sdat = ser_data; p_par = par_data;
  end

  task automatic send(input logic [7:0] d, input bit a, input bit e);
    @(negedge clk);
    in_data = d; in_is_audio = a; in_err = e; in_valid = 1;
    while (!in_ready) @(negedge clk);
    exp_d.push_back(d); exp_a.push_back(a); exp_e.push_back(e);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    rst_n = 0; mode_par = 0; in_valid = 0; in_data = 0; in_is_audio = 0; in_err = 0;
    vreq_n = 0; areq_n = 0; nb = 0; acc = 0; gap_chk = 0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(!vid_vld && !aud_vld && err_n && !ser_clk && !ser_data && par_data == 0 && in_ready,
        "R1 reset outputs", {vid_vld, aud_vld, err_n, ser_clk, ser_data, in_ready}, 6'b001001);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(!vid_vld && !aud_vld && err_n && in_ready && par_data == 0, "R1 after release",
        {vid_vld, aud_vld, err_n, in_ready}, 4'b0011);
    mon_en = 1;

    // R2 R3 R5 R9: serial sweep over all byte values
    tb_par = 0; mode_par = 0;
    for (int i = 0; i < 256; i++) send(8'(i), (i % 7) == 3, (i % 5) == 0);
    wait_idle();
    chk(rcv == 256, "R2 serial count", rcv, 256);

    // R6 R3 R5 R9: parallel sweep
    tb_par = 1; mode_par = 1;
    for (int i = 0; i < 256; i++) send(8'(255 - i), (i % 3) == 1, (i % 4) == 2);
    wait_idle();
    chk(rcv == 512, "R6 parallel count", rcv, 512);

    // R4 R8: video held back without request
    tb_par = 0; mode_par = 0; vreq_n = 1;
    send(8'hA5, 0, 1);
    repeat (40) @(negedge clk);
    chk(rcv == 512 && !vid_vld, "R4 video gated", rcv, 512);
    chk(!in_ready, "R8 holds one byte", in_ready, 0);
    vreq_n = 0;
    wait_idle();
    chk(rcv == 513, "R4 video released", rcv, 513);

    // R4: audio held back without request, video request present
    areq_n = 1;
    send(8'h3C, 1, 0);
    repeat (40) @(negedge clk);
    chk(rcv == 513 && !aud_vld, "R4 audio gated", rcv, 513);
    areq_n = 0;
    wait_idle();
    chk(rcv == 514, "R4 audio released", rcv, 514);

    // R7: request withdrawn mid-byte (serial)
    send(8'h96, 0, 1);
    while (!vid_vld) @(negedge clk);
    repeat (3) @(negedge clk);
    vreq_n = 1;
    repeat (30) @(negedge clk);
    chk(rcv == 515 && !vid_vld, "R7 byte completed", rcv, 515);
    vreq_n = 0;

    // R7: request withdrawn at parallel strobe
    tb_par = 1; mode_par = 1;
    repeat (2) @(negedge clk);
    send(8'h5A, 0, 0);
    while (!vid_vld) @(negedge clk);
    vreq_n = 1;
    repeat (10) @(negedge clk);
    chk(rcv == 516, "R7 parallel completed", rcv, 516);
    vreq_n = 0;

    chk(exp_d.size() == 0, "R3 nothing pending", exp_d.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule